// File: doc/BRIEF.md
# Platform Control and Status Register File

This block is a small 32-bit register window that a development platform's processor reads to learn about the board and writes to request a system reset. It fully decodes a 16-bit offset inside a 4 KiB window. Most words are constants or are built from strap pins: the installed memory size in GiB and the reference clock frequency in MHz. One control word carries a self-clearing reset-request bit. Only accesses of exactly four bytes take effect. Any other size, and any offset with no register behind it, is answered with zero data and the unimplemented-access flag raised.

Requests arrive on a valid/ready channel. `req_ready` is held high outside reset, so the block never applies back-pressure. A request is taken on every rising clock edge at which `req_valid` is high. Exactly one response follows on the next cycle, with `rsp_valid` high for one cycle. The response channel has no ready signal, so the consumer must accept each response in the cycle it appears. A write also returns a response, carrying zero data and the flag.

Top module: `plat_ctrl_regs`

## Requirements
- R1: A request whose `req_size` is not 4 (bytes) has no effect. Its response has `rsp_rdata` = 0 and `rsp_unimp` = 1, for reads and writes alike, and it never raises `sys_rst_req`.
- R2: Four-byte reads at offsets 0x000, 0x004 and 0x008 (build identity and the two change-list words) return 0 with `rsp_unimp` = 0.
- R3: A four-byte read at offset 0x014 (memory status) returns 0x0000_0005, with bit 0 (locked) and bit 2 (calibrated) set, and `rsp_unimp` = 0.
- R4: A four-byte read at offset 0x030 (clock divider word) returns bits 7:0 = 1, bits 15:8 = `strap_ref_mhz`, bits 23:16 = 1 and bits 31:24 = 1.
- R5: A four-byte read at offset 0x034 (build options) returns 0x0000_000E: bits 1 to 3 are set for three enabled link ports, and bit 0 is clear.
- R6: A four-byte read at offset 0x038 (memory configuration) returns bits 3:0 = `strap_mem_gib`, clamped to 15 when the strap exceeds 15, and bits 15:4 all ones. Bits 31:16 are zero.
- R7: Four-byte writes to offsets 0x000, 0x004, 0x008, 0x00C, 0x014, 0x018, 0x030, 0x034 and 0x038 change nothing. They give `rsp_unimp` = 0 and do not raise `sys_rst_req`.
- R8: A four-byte write to offset 0x010 with `req_wdata` bit 4 set raises `sys_rst_req` for exactly one cycle, in the cycle after the write is taken. The same write with bit 4 clear raises nothing. Neither write flags the access.
- R9: Four-byte reads at any offset not listed in R2 to R6 return 0 with `rsp_unimp` = 1. This includes 0x00C, 0x010, 0x018, unaligned offsets and offsets above 0x038. Four-byte writes at offsets not listed in R7 or R8 are dropped with `rsp_unimp` = 1.
- R10: After reset `rsp_valid`, `rsp_unimp`, `rsp_rdata` and `sys_rst_req` are 0 and `req_ready` is 1. Each taken request produces exactly one response, in the next cycle. Write responses carry `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (high outside reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset, fully decoded |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| strap_mem_gib | input | 6 | Installed memory size in GiB |
| strap_ref_mhz | input | 8 | Reference clock frequency in MHz |
| rsp_valid | output | 1 | Response present, one cycle per request |
| rsp_rdata | output | 32 | Read data (0 for writes and flagged accesses) |
| rsp_unimp | output | 1 | Access was of a bad size or hit no register |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Assertions check on every cycle that responses follow requests one-for-one with one cycle of latency, and that wrong-sized requests come back flagged with zero data. They also check that flagged responses never carry data, and that the reset request is one cycle wide and only ever follows a four-byte write to the reset control offset. The exact contents of each status word, the strap clamping, and which offsets accept writes silently can only be shown by the bench. It sweeps every offset in the low window for both directions, every access size, and the full range of the memory-size strap.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  // Offsets whose position software relies on
  localparam logic [ADDR_W-1:0] OFS_BUILD_ID  = 16'h0000;
  localparam logic [ADDR_W-1:0] OFS_CORE_CL   = 16'h0004;
  localparam logic [ADDR_W-1:0] OFS_WRAP_CL   = 16'h0008;
  localparam logic [ADDR_W-1:0] OFS_CLK_STAT  = 16'h000C;
  localparam logic [ADDR_W-1:0] OFS_RST_CTL   = 16'h0010;
  localparam logic [ADDR_W-1:0] OFS_MEM_STAT  = 16'h0014;
  localparam logic [ADDR_W-1:0] OFS_LINK_STAT = 16'h0018;
  localparam logic [ADDR_W-1:0] OFS_CLK_DIV   = 16'h0030;
  localparam logic [ADDR_W-1:0] OFS_BUILD_OPT = 16'h0034;
  localparam logic [ADDR_W-1:0] OFS_MEM_CFG   = 16'h0038;

  typedef enum logic [3:0] {
    SEL_BUILD_ID,
    SEL_CORE_CL,
    SEL_WRAP_CL,
    SEL_CLK_STAT,
    SEL_RST_CTL,
    SEL_MEM_STAT,
    SEL_LINK_STAT,
    SEL_CLK_DIV,
    SEL_BUILD_OPT,
    SEL_MEM_CFG,
    SEL_NONE
  } reg_sel_e;

  // Fixed field values
  localparam logic [DATA_W-1:0] MEM_STAT_WORD  = 32'h0000_0005;
  localparam logic [DATA_W-1:0] BUILD_OPT_WORD = 32'h0000_000E;
  localparam logic [7:0]        CLK_UNITY      = 8'd1;
  localparam logic [11:0]       MEM_CFG_MHZ    = 12'hFFF;

endpackage

// File: rtl/plat_addr_decode.sv
module plat_addr_decode
  import plat_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              rd_known,
  output logic              wr_known
);

  always_comb begin
    unique case (addr)
      OFS_BUILD_ID:  sel = SEL_BUILD_ID;
      OFS_CORE_CL:   sel = SEL_CORE_CL;
      OFS_WRAP_CL:   sel = SEL_WRAP_CL;
      OFS_CLK_STAT:  sel = SEL_CLK_STAT;
      OFS_RST_CTL:   sel = SEL_RST_CTL;
      OFS_MEM_STAT:  sel = SEL_MEM_STAT;
      OFS_LINK_STAT: sel = SEL_LINK_STAT;
      OFS_CLK_DIV:   sel = SEL_CLK_DIV;
      OFS_BUILD_OPT: sel = SEL_BUILD_OPT;
      OFS_MEM_CFG:   sel = SEL_MEM_CFG;
      default:       sel = SEL_NONE;
    endcase
  end

  // Offsets that return a defined word on a read
  always_comb begin
    case (sel)
      SEL_BUILD_ID, SEL_CORE_CL, SEL_WRAP_CL, SEL_MEM_STAT,
      SEL_CLK_DIV, SEL_BUILD_OPT, SEL_MEM_CFG: rd_known = 1'b1;
      default:                                 rd_known = 1'b0;
    endcase
  end

  // Every named offset takes a write without complaint
  assign wr_known = (sel != SEL_NONE);

endmodule

// File: rtl/plat_read_mux.sv
module plat_read_mux
  import plat_regs_pkg::*;
#(
  parameter int unsigned MEMSZ_W = 6,
  parameter int unsigned FREQ_W  = 8
) (
  input  reg_sel_e            sel,
  input  logic [MEMSZ_W-1:0]  strap_mem_gib,
  input  logic [FREQ_W-1:0]   strap_ref_mhz,
  output logic [DATA_W-1:0]   word
);

  localparam int unsigned SIZE_FIELD_W = 4;
  localparam int unsigned SIZE_MAX     = (1 << SIZE_FIELD_W) - 1;

  logic [SIZE_FIELD_W-1:0] size_field;
  logic [7:0]              freq_field;

  generate
    if (MEMSZ_W > SIZE_FIELD_W) begin : g_clamp
      always_comb begin
        if (strap_mem_gib > MEMSZ_W'(SIZE_MAX)) size_field = SIZE_FIELD_W'(SIZE_MAX);
        else                                    size_field = strap_mem_gib[SIZE_FIELD_W-1:0];
      end
    end else begin : g_pad
      assign size_field = SIZE_FIELD_W'(strap_mem_gib);
    end
  endgenerate

  assign freq_field = 8'(strap_ref_mhz);

  always_comb begin
    case (sel)
      SEL_MEM_STAT:  word = MEM_STAT_WORD;
      SEL_CLK_DIV:   word = {CLK_UNITY, CLK_UNITY, freq_field, CLK_UNITY};
      SEL_BUILD_OPT: word = BUILD_OPT_WORD;
      SEL_MEM_CFG:   word = {16'h0000, MEM_CFG_MHZ, size_field};
      default:       word = '0;
    endcase
  end

endmodule

// File: rtl/plat_reset_req.sv
module plat_reset_req (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= trigger & ~pulse;
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse); // R8

endmodule

// File: rtl/plat_ctrl_regs.sv
module plat_ctrl_regs
  import plat_regs_pkg::*;
#(
  parameter int unsigned MEMSZ_W = 6,
  parameter int unsigned FREQ_W  = 8,
  parameter int unsigned SIZE_W  = 4,
  parameter int unsigned RST_BIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [15:0]        req_addr,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic [31:0]        req_wdata,
  input  logic [MEMSZ_W-1:0] strap_mem_gib,
  input  logic [FREQ_W-1:0]  strap_ref_mhz,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_unimp,
  output logic               sys_rst_req
);

  localparam int unsigned WORD_BYTES = DATA_W / 8;

  reg_sel_e          sel;
  logic              rd_known;
  logic              wr_known;
  logic [DATA_W-1:0] rd_word;
  logic              size_ok;
  logic              take;
  logic              nxt_unimp;
  logic [DATA_W-1:0] nxt_data;
  logic              rst_trigger;
  logic              unused_wdata;
  logic              ready_q;

  plat_addr_decode u_dec (
    .addr     (req_addr),
    .sel      (sel),
    .rd_known (rd_known),
    .wr_known (wr_known)
  );

  plat_read_mux #(
    .MEMSZ_W (MEMSZ_W),
    .FREQ_W  (FREQ_W)
  ) u_rmux (
    .sel           (sel),
    .strap_mem_gib (strap_mem_gib),
    .strap_ref_mhz (strap_ref_mhz),
    .word          (rd_word)
  );

  assign unused_wdata = ^req_wdata;
  assign size_ok      = (req_size == SIZE_W'(WORD_BYTES));
  assign take         = req_valid & req_ready;

  always_comb begin
    if (!size_ok) begin
      nxt_unimp = 1'b1;
      nxt_data  = '0;
    end else if (req_write) begin
      nxt_unimp = ~wr_known;
      nxt_data  = '0;
    end else begin
      nxt_unimp = ~rd_known;
      nxt_data  = rd_known ? rd_word : '0;
    end
  end

  assign rst_trigger = take & req_write & size_ok & (sel == SEL_RST_CTL) & req_wdata[RST_BIT];

  plat_reset_req u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (rst_trigger),
    .pulse   (sys_rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_unimp <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= take;
      rsp_rdata <= take ? nxt_data : '0;
      rsp_unimp <= take ? nxt_unimp : 1'b0;
    end
  end

  assign req_ready = ready_q;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid); // R10
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && req_ready) |=> !rsp_valid); // R10
  AST_BAD_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && req_size != SIZE_W'(WORD_BYTES)) |=> (rsp_unimp && rsp_rdata == '0)); // R1
  AST_UNIMP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) rsp_unimp |-> (rsp_valid && rsp_rdata == '0)); // R9
  AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_req |-> $past(req_valid && req_write && req_size == SIZE_W'(WORD_BYTES) && req_addr == OFS_RST_CTL)); // R8

endmodule

// File: tb/plat_ctrl_regs_tb_top.sv
module plat_ctrl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [5:0]  strap_mem_gib = 6'd1;
  logic [7:0]  strap_ref_mhz = 8'd25;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_unimp;
  logic        sys_rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  plat_ctrl_regs dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .strap_mem_gib (strap_mem_gib),
    .strap_ref_mhz (strap_ref_mhz),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_unimp     (rsp_unimp),
    .sys_rst_req   (sys_rst_req)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic string read_req(input logic [15:0] a, input logic [3:0] s);
    if (s != 4) return "R1";
    case (a)
      16'h0000, 16'h0004, 16'h0008: return "R2";
      16'h0014: return "R3";
      16'h0030: return "R4";
      16'h0034: return "R5";
      16'h0038: return "R6";
      default:  return "R9";
    endcase
  endfunction

  // Expected {flag, data} of a read, from the requirements
  function automatic logic [32:0] model_read(input logic [15:0] a, input logic [3:0] s,
                                             input int mem, input int mhz);
    int sz;
    if (s != 4) return {1'b1, 32'h0};
    sz = (mem > 15) ? 15 : mem;
    case (a)
      16'h0000, 16'h0004, 16'h0008: return {1'b0, 32'h0};
      16'h0014: return {1'b0, 32'h5};
      16'h0030: return {1'b0, 32'(1 * 16777216 + 1 * 65536 + mhz * 256 + 1)};
      16'h0034: return {1'b0, 32'hE};
      16'h0038: return {1'b0, 32'(16 * 4095 + sz)};
      default:  return {1'b1, 32'h0};
    endcase
  endfunction

  function automatic bit model_wr_flag(input logic [15:0] a, input logic [3:0] s);
    if (s != 4) return 1'b1;
    case (a)
      16'h0000, 16'h0004, 16'h0008, 16'h000C, 16'h0010, 16'h0014,
      16'h0018, 16'h0030, 16'h0034, 16'h0038: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string write_req(input logic [15:0] a, input logic [3:0] s);
    if (s != 4) return "R1";
    if (a == 16'h0010) return "R8";
    return model_wr_flag(a, s) ? "R9" : "R7";
  endfunction

  // One access; checks response, reset pulse and that the pulse is gone a cycle later
  task automatic access(input bit wr, input logic [15:0] a, input logic [3:0] s,
                        input logic [31:0] wd);
    logic [32:0] exp;
    bit          exp_rst;
    string       rq;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      rq      = write_req(a, s);
      exp     = {model_wr_flag(a, s), 32'h0};
      exp_rst = (s == 4) && (a == 16'h0010) && wd[4];
    end else begin
      rq      = read_req(a, s);
      exp     = model_read(a, s, int'(strap_mem_gib), int'(strap_ref_mhz));
      exp_rst = 1'b0;
    end
    check(rsp_valid == 1'b1, "R10", "rsp_valid", 32'(rsp_valid), 32'h1);
    check(rsp_rdata == exp[31:0] && rsp_unimp == exp[32], rq,
          $sformatf("%s ofs 0x%04h size %0d {flag,data}", wr ? "write" : "read", a, s),
          {rsp_unimp, rsp_rdata[30:0]}, {exp[32], exp[30:0]});
    check(sys_rst_req == exp_rst, wr ? rq : "R8", "sys_rst_req", 32'(sys_rst_req), 32'(exp_rst));
    @(negedge clk);
    check(sys_rst_req == 1'b0 && rsp_valid == 1'b0, "R8", "idle after pulse",
          {30'h0, sys_rst_req, rsp_valid}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && sys_rst_req == 0 && rsp_unimp == 0 && rsp_rdata == 0,
          "R10", "outputs in reset", {rsp_rdata[28:0], rsp_valid, sys_rst_req, rsp_unimp}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R10", "idle after reset",
          {30'h0, req_ready, rsp_valid}, 32'h2);

    // Read and write sweep over the low window, every byte offset
    for (int a = 0; a < 128; a++) access(1'b0, 16'(a), 4'd4, 32'h0);
    for (int a = 0; a < 128; a++) access(1'b1, 16'(a), 4'd4, 32'hFFFF_FFFF);
    // Offsets aliasing outside the window
    access(1'b0, 16'h1030, 4'd4, 32'h0);
    access(1'b0, 16'hFFFF, 4'd4, 32'h0);
    access(1'b1, 16'h1010, 4'd4, 32'h10);

    // Every access size on live offsets
    for (int s = 0; s < 16; s++) begin
      access(1'b0, 16'h0014, 4'(s), 32'h0);
      access(1'b1, 16'h0010, 4'(s), 32'h0000_0010);
    end

    // Reset control: only bit 4 counts
    access(1'b1, 16'h0010, 4'd4, 32'hFFFF_FFEF);
    access(1'b1, 16'h0010, 4'd4, 32'h0000_0010);

    // Strap sweeps (R4, R6)
    for (int m = 0; m < 64; m++) begin
      strap_mem_gib = 6'(m);
      access(1'b0, 16'h0038, 4'd4, 32'h0);
    end
    for (int f = 0; f < 256; f += 17) begin
      strap_ref_mhz = 8'(f);
      access(1'b0, 16'h0030, 4'd4, 32'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule